// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an 8K x 8 asynchronous static RAM that has two chip enables of opposite polarity, an active-low output enable and an active-low write enable. The host raises a request with a direction bit, an address and write data, and holds them until a one-cycle acknowledge. The sequencer then runs one complete memory cycle, with every phase stretched to a whole number of clock periods. Read data comes back on a registered output in the same cycle as the acknowledge.

Each minimum delay is a nanosecond figure chosen by a speed-grade parameter. It is divided by the clock period, rounded up, and given at least one cycle. Writes keep output enable high. The sequencer drops write enable first, waits for the memory's outputs to float, and only then turns on its own data drivers. It releases them on the same edge on which write enable rises. After every read it holds the device deselected for the output-float time before it may drive the shared bus again.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, both enables are inactive (`mem_cs_n`=1, `mem_cs`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dout_en`=0 and `hack`=0.
- R2: The two enables always agree: the device is either selected (`mem_cs_n`=0 and `mem_cs`=1) or deselected (`mem_cs_n`=1 and `mem_cs`=0).
- R3: `mem_oe_n` is low only while the device is selected, and `mem_oe_n` and `mem_we_n` are never low together.
- R4: A read holds select and output enable active for RD = max(ceil(tAA), ceil(tOE), ceil(tRC)) clock cycles (4 at the default slow grade with a 20 ns clock). `mem_din` is captured at the last of these edges. On that same edge the strobes go inactive, `hack` rises and `hrdata` shows the captured byte.
- R5: A write holds `mem_we_n` low for WZ + DV cycles, where WZ = ceil(tWHZ) and DV = max(ceil(tDW), ceil(tWP) - WZ, 1). This is 2 + 2 at the default. `mem_dout_en` is high only during the last DV of those cycles, and it falls on the edge where `mem_we_n` rises and `hack` pulses.
- R6: `mem_addr` does not change while the device is selected, and `mem_dout` does not change while `mem_dout_en` is high.
- R7: After a read, the device stays deselected for at least HZ = ceil(tHZ) cycles (2 at the default) before the next select. The drivers are never on while the memory may still drive the bus.
- R8: Changes to `hwrite`, `haddr` or `hwdata` after a request has been accepted do not affect the cycle in flight. The write stores the data given at acceptance and the read returns the addressed byte.
- R9: Each accepted request yields exactly one `hack` pulse, one cycle long. The host holds `hreq` until it sees `hack`, and a request is taken only when the sequencer is idle.
- R10: Timing is chosen by `FAST_GRADE`. The fast grade uses tAA/tOE/tRC 35/25/35, tWP 25, tDW 20, tWHZ 15, tWC 35 and tHZ 25 ns. The slow grade uses 70/35/70, 50, 30, 25, 70 and 35 ns. Each value is rounded up to whole `CLK_NS` periods with a minimum of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hreq | input | 1 | Host request, held until `hack` |
| hwrite | input | 1 | 1 = write, 0 = read |
| haddr | input | ADDR_W | Host word address |
| hwdata | input | DATA_W | Host write data |
| hrdata | output | DATA_W | Registered read data |
| hack | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data toward memory |
| mem_dout_en | output | 1 | Data driver enable |
| mem_din | input | DATA_W | Data from memory |
| mem_cs_n | output | 1 | Active-low chip enable |
| mem_cs | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |

## Verification
Assertions check the strobe rules on every cycle: the enables agree, output and write enable never overlap, the drivers stay inside the write-enable window and are released with it, and address and data hold while they matter. The scenarios are needed for the cycle counts. The bench's memory model returns garbage until output enable has been low for the full access count and flags any bus contention during its float window. Those scenarios also cover the post-read deselect gap, the data actually stored and returned, and the host changing its inputs mid-cycle.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RD_ACC = 3'd1,
      ST_RD_FLT = 3'd2,
      ST_WR_FLT = 3'd3,
      ST_WR_DRV = 3'd4,
      ST_WR_REC = 3'd5
   } seq_state_t;

   // nanoseconds to whole clock periods, rounded up
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
      if (ns == 0) return 0;
      return (ns + per - 1) / per;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_host_regs.sv
module sram_host_regs #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_req,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [DATA_W-1:0] hwdata,
   input  logic              take_rd,
   input  logic [DATA_W-1:0] mem_din,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic [DATA_W-1:0] hrdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dout <= '0;
      end else if (take_req) begin
         mem_addr <= haddr;
         mem_dout <= hwdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hrdata <= '0;
      else if (take_rd)
         hrdata <= mem_din;
   end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int CLK_NS     = 20,
   parameter bit FAST_GRADE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hreq,
   input  logic              hwrite,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [DATA_W-1:0] hwdata,
   output logic [DATA_W-1:0] hrdata,
   output logic              hack,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_cs_n,
   output logic              mem_cs,
   output logic              mem_oe_n,
   output logic              mem_we_n
);

   // R10: per-grade minimums in ns
   localparam int unsigned T_AA  = FAST_GRADE ? 35 : 70;
   localparam int unsigned T_OE  = FAST_GRADE ? 25 : 35;
   localparam int unsigned T_RC  = FAST_GRADE ? 35 : 70;
   localparam int unsigned T_WP  = FAST_GRADE ? 25 : 50;
   localparam int unsigned T_DW  = FAST_GRADE ? 20 : 30;
   localparam int unsigned T_WHZ = FAST_GRADE ? 15 : 25;
   localparam int unsigned T_WC  = FAST_GRADE ? 35 : 70;
   localparam int unsigned T_HZ  = FAST_GRADE ? 25 : 35;

   localparam int unsigned RD_CYC  = umax(1, umax(umax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_OE, CLK_NS)),
                                                  ns2cyc(T_RC, CLK_NS)));
   localparam int unsigned HZ_CYC  = umax(1, ns2cyc(T_HZ, CLK_NS));
   localparam int unsigned WZ_CYC  = umax(1, ns2cyc(T_WHZ, CLK_NS));
   localparam int unsigned WP_CYC  = ns2cyc(T_WP, CLK_NS);
   localparam int unsigned DV_CYC  = umax(umax(1, ns2cyc(T_DW, CLK_NS)),
                                          (WP_CYC > WZ_CYC) ? WP_CYC - WZ_CYC : 1);
   localparam int unsigned WC_CYC  = ns2cyc(T_WC, CLK_NS);
   localparam int unsigned REC_CYC = (WC_CYC > WZ_CYC + DV_CYC) ? WC_CYC - WZ_CYC - DV_CYC : 0;
   localparam int unsigned MAX_CYC = umax(umax(RD_CYC, HZ_CYC), umax(umax(WZ_CYC, DV_CYC), REC_CYC));
   localparam int          CNT_W   = $clog2(MAX_CYC + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1 || CLK_NS < 1) begin : g_bad_param
         $error("sram_seq_ctrl: widths and clock period must be positive");
      end
   endgenerate

   seq_state_t st_q;
   logic       cs_n_q, cs_q, oe_n_q, we_n_q, den_q, ack_q;
   logic       t_load, t_zero;
   logic [CNT_W-1:0] t_val;
   logic       take_req, take_rd;
   seq_state_t wr_exit_st;

   // variant: recovery phase only when the write cycle time is not met already
   generate
      if (REC_CYC > 0) begin : g_rec
         assign wr_exit_st = ST_WR_REC;
      end else begin : g_norec
         assign wr_exit_st = ST_IDLE;
      end
   endgenerate

   assign take_req = (st_q == ST_IDLE) && hreq;
   assign take_rd  = (st_q == ST_RD_ACC) && t_zero;

   // phase timer loading: each phase lasts exactly its count of cycles
   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      unique case (st_q)
         ST_IDLE: if (hreq) begin
            t_load = 1'b1;
            t_val  = hwrite ? CNT_W'(WZ_CYC - 1) : CNT_W'(RD_CYC - 1);
         end
         ST_RD_ACC: if (t_zero) begin
            t_load = 1'b1;
            t_val  = CNT_W'(HZ_CYC - 1);
         end
         ST_WR_FLT: if (t_zero) begin
            t_load = 1'b1;
            t_val  = CNT_W'(DV_CYC - 1);
         end
         ST_WR_DRV: if (t_zero && REC_CYC > 0) begin
            t_load = 1'b1;
            t_val  = CNT_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cs_n_q <= 1'b1;
         cs_q   <= 1'b0;
         oe_n_q <= 1'b1;
         we_n_q <= 1'b1;
         den_q  <= 1'b0;
         ack_q  <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (hreq) begin
               cs_n_q <= 1'b0;
               cs_q   <= 1'b1;
               if (hwrite) begin
                  we_n_q <= 1'b0;
                  st_q   <= ST_WR_FLT;
               end else begin
                  oe_n_q <= 1'b0;
                  st_q   <= ST_RD_ACC;
               end
            end
            ST_RD_ACC: if (t_zero) begin
               cs_n_q <= 1'b1;
               cs_q   <= 1'b0;
               oe_n_q <= 1'b1;
               ack_q  <= 1'b1;
               st_q   <= ST_RD_FLT;
            end
            ST_RD_FLT: if (t_zero) st_q <= ST_IDLE;
            ST_WR_FLT: if (t_zero) begin
               den_q <= 1'b1;
               st_q  <= ST_WR_DRV;
            end
            ST_WR_DRV: if (t_zero) begin
               we_n_q <= 1'b1;
               den_q  <= 1'b0;
               cs_n_q <= 1'b1;
               cs_q   <= 1'b0;
               ack_q  <= 1'b1;
               st_q   <= wr_exit_st;
            end
            ST_WR_REC: if (t_zero) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   sram_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_req (take_req),
      .haddr    (haddr),
      .hwdata   (hwdata),
      .take_rd  (take_rd),
      .mem_din  (mem_din),
      .mem_addr (mem_addr),
      .mem_dout (mem_dout),
      .hrdata   (hrdata)
   );

   assign mem_cs_n    = cs_n_q;
   assign mem_cs      = cs_q;
   assign mem_oe_n    = oe_n_q;
   assign mem_we_n    = we_n_q;
   assign mem_dout_en = den_q;
   assign hack        = ack_q;

   logic sel;
   assign sel = !mem_cs_n && mem_cs;

   a_r2_enables_agree: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs_n == !mem_cs);

   a_r3_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> sel);

   a_r3_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   a_r5_drive_in_we: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dout_en |-> (!mem_we_n && sel));

   a_r5_release_with_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> ($past(mem_dout_en) && !mem_dout_en));

   a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && $past(sel)) |-> $stable(mem_addr));

   a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout));

   a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      hack |=> !hack);

   a_r9_ack_ends_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hack) |-> !sel);

endmodule

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

   localparam int AW  = 13;
   localparam int DW  = 8;
   localparam int PER = 20;

   // expected cycle counts for the slow grade (R10), computed here
   function automatic int up(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction
   localparam int E_RD = (up(70) > up(35)) ? up(70) : up(35);
   localparam int E_HZ = up(35);
   localparam int E_WZ = up(25);
   localparam int E_DV = (up(30) > up(50) - up(25)) ? up(30) : up(50) - up(25);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hreq = 1'b0, hwrite = 1'b0;
   logic [AW-1:0] haddr = '0;
   logic [DW-1:0] hwdata = '0;
   logic [DW-1:0] hrdata;
   logic hack;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dout;
   logic mem_dout_en;
   logic [DW-1:0] mem_din = 8'hE7;
   logic mem_cs_n, mem_cs, mem_oe_n, mem_we_n;

   always #10 clk = ~clk;

   sram_seq_ctrl u_sram_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .hreq(hreq), .hwrite(hwrite), .haddr(haddr),
      .hwdata(hwdata), .hrdata(hrdata), .hack(hack), .mem_addr(mem_addr),
      .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
      .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   logic [7:0] model_mem [int];
   logic [7:0] ref_mem   [int];
   bit         kind_q [$];
   logic [7:0] exp_q  [$];
   int         n_ops = 0;
   int         n_acks = 0;

   function automatic logic [7:0] rd_model(input int a);
      return model_mem.exists(a) ? model_mem[a] : 8'h00;
   endfunction
   function automatic logic [7:0] rd_ref(input int a);
      return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
   endfunction

   // memory model and strobe-timing monitor
   int  oe_cnt = 0, we_cnt = 0, dv_cnt = 0, hz_left = 0, desel_cnt = 100;
   bit  p_oe_low = 0, p_we_low = 0, p_sel = 0, last_rd = 0;
   logic [7:0] pend_d;
   int  pend_a;
   always @(negedge clk) if (rst_n) begin
      bit sel;
      sel = !mem_cs_n && mem_cs;
      if (hz_left > 0) hz_left--;
      if (p_oe_low && mem_oe_n) begin
         chk(oe_cnt == E_RD, "R4", "oe low cycles", oe_cnt, E_RD);
         chk(hack == 1'b1, "R4", "ack with oe rise", hack, 1);
         oe_cnt  = 0;
         hz_left = E_HZ;
         last_rd = 1;
      end
      if (sel && !mem_oe_n) oe_cnt++;
      if (sel && !p_sel) begin
         if (last_rd) chk(desel_cnt >= E_HZ, "R7", "deselect gap after read", desel_cnt, E_HZ);
         last_rd = 0;
      end
      desel_cnt = sel ? 0 : desel_cnt + 1;
      if (mem_dout_en) begin
         chk(!((sel && !mem_oe_n) || hz_left > 0), "R7", "drive while memory drives", 1, 0);
         dv_cnt++;
         pend_d = mem_dout;
         pend_a = int'(mem_addr);
      end
      if (!mem_we_n) we_cnt++;
      if (p_we_low && mem_we_n) begin
         chk(we_cnt == E_WZ + E_DV, "R5", "we low cycles", we_cnt, E_WZ + E_DV);
         chk(dv_cnt == E_DV, "R5", "driver cycles", dv_cnt, E_DV);
         chk(hack == 1'b1, "R9", "ack with we rise", hack, 1);
         model_mem[pend_a] = pend_d;
         we_cnt = 0;
         dv_cnt = 0;
      end
      mem_din = (sel && !mem_oe_n && oe_cnt >= E_RD) ? rd_model(int'(mem_addr)) : 8'hE7;
      p_oe_low = sel && !mem_oe_n;
      p_we_low = !mem_we_n;
      p_sel    = sel;
   end

   // scoreboard monitor
   bit p_ack = 0;
   always @(negedge clk) if (rst_n) begin
      if (hack) begin
         bit k;
         logic [7:0] e;
         n_acks++;
         chk(!p_ack, "R9", "ack longer than one cycle", 1, 0);
         if (kind_q.size() == 0) chk(0, "R9", "ack without request", 1, 0);
         else begin
            k = kind_q.pop_front();
            if (!k) begin
               e = exp_q.pop_front();
               chk(hrdata == e, "R8", "read data", hrdata, e);
            end
         end
      end
      p_ack = hack;
   end

   task automatic op(input bit w, input int a, input logic [7:0] d, input bit meddle);
      int n;
      @(negedge clk);
      hreq = 1'b1; hwrite = w; haddr = AW'(a); hwdata = d;
      n_ops++;
      kind_q.push_back(w);
      if (w) ref_mem[a] = d;
      else exp_q.push_back(rd_ref(a));
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (meddle && n == 2) begin
            hwrite = ~w; haddr = ~AW'(a); hwdata = ~d;
         end
      end while (!hack);
      hreq = 1'b0;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_mem[5] = 8'h3C; ref_mem[5] = 8'h3C;
      repeat (3) @(negedge clk);
      chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n, "R1", "strobes in reset", 0, 1);
      chk(!mem_dout_en && !hack, "R1", "driver/ack in reset", mem_dout_en, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dout_en, "R1", "idle after reset", 0, 1);
      chk(mem_cs_n == !mem_cs, "R2", "enables agree idle", mem_cs, 0);
      op(1'b0, 5, 8'h00, 1'b0);            // R4 preloaded word
      op(1'b1, 0, 8'hA5, 1'b0);            // R5 lowest address
      op(1'b1, 8191, 8'hFF, 1'b0);         // highest address
      op(1'b0, 0, 8'h00, 1'b0);
      op(1'b0, 8191, 8'h00, 1'b0);
      op(1'b1, 100, 8'h00, 1'b0);
      op(1'b0, 100, 8'h00, 1'b0);
      op(1'b1, 200, 8'h5A, 1'b1);          // R8 meddle during write
      op(1'b0, 200, 8'h00, 1'b1);          // R8 meddle during read
      op(1'b0, ~13'd200, 8'h00, 1'b0);     // address the meddle used stays untouched
      for (int i = 0; i < 8; i++) op(1'b1, 1000 + i * 37, 8'(i * 29 + 1), 1'b0);
      for (int i = 0; i < 8; i++) op(1'b0, 1000 + i * 37, 8'h00, 1'b0);
      repeat (6) @(negedge clk);
      chk(n_acks == n_ops, "R9", "ack count", n_acks, n_ops);
      chk(kind_q.size() == 0, "R9", "pending ops", kind_q.size(), 0);
      chk(mem_cs_n && !mem_cs && !mem_dout_en, "R2", "deselected at end", mem_cs, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule